// File: doc/BRIEF.md
# Double-Buffered Video Memory Bank Swapper

This block sits between a CPU, a display scanout engine and two video memory banks. At any moment one bank belongs to the CPU and the other belongs to the display. The CPU draws the next frame into its own bank while the display reads the finished frame from the other bank. The CPU asks for an exchange by writing a one-bit flip value through a control strobe. The block records that request at once, carries it into the display clock domain and commits it only while vertical blanking is high, so a frame is never shown half old and half new.

The CPU and display sides run on independent clocks. The committed bank choice lives in the display domain. A synchronized copy of it returns to the CPU domain, where it is shown as status together with a flag that says a request is still waiting. A CPU access that is already under way keeps the bank it started on, even if the swap commits in the middle of it. Each bank has its own address, write data, write enable, enable and read data pins. The block drives each bank from whichever side owns it.

Top module: `vram_swap_top`

## Requirements
- R1: After reset the CPU owns bank 0, the display owns bank 1, `flipPending` is 0 and `cpuOwnBank` is 0.
- R2: The bank the CPU owns takes `cpuAddr`, `cpuWdata` and enable `cpuSel`, and its write enable is `cpuSel & cpuWe`. `cpuRdata` returns that bank's read data.
- R3: The bank the display owns takes `dispAddr` and enable `dispRe`, and its write enable stays 0. `dispRdata` returns that bank's read data.
- R4: While `vblank` is low, a flip request changes neither bank ownership nor any routing. `flipPending` stays 1 for the whole wait.
- R5: A flip value of 1 gives the CPU bank 1 and the display bank 0. A value of 0 gives the CPU bank 0 and the display bank 1. The new value is committed on display clock cycles in which `vblank` is high. After the commit, `cpuOwnBank` shows the new CPU bank and `flipPending` returns to 0.
- R6: A bank write enable is high only when the CPU is writing, and the two banks are never write-enabled at the same time.
- R7: While `cpuSel` stays high, the CPU keeps the bank it held at the start of the access, even if a swap commits during the access. The next access uses the new bank.
- R8: `flipPending` is 1 when the last requested flip value differs from the committed value seen in the CPU domain. Writing a flip value equal to the current one leaves `flipPending` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | CPU clock |
| cpuRstN | input | 1 | CPU-domain reset, active low, asynchronous |
| cpuSel | input | 1 | CPU access active; held high for the length of the access |
| cpuWe | input | 1 | CPU access is a write |
| cpuAddr | input | ADDR_W | CPU address |
| cpuWdata | input | DATA_W | CPU write data |
| cpuRdata | output | DATA_W | Read data from the CPU's bank |
| flipWe | input | 1 | Control register write strobe |
| flipVal | input | 1 | Requested flip value |
| cpuOwnBank | output | 1 | Bank the next CPU access will use (synchronized commit) |
| flipPending | output | 1 | Request not yet committed |
| dispClk | input | 1 | Display clock |
| dispRstN | input | 1 | Display-domain reset, active low, asynchronous |
| vblank | input | 1 | Vertical blanking, display domain |
| dispRe | input | 1 | Display read enable |
| dispAddr | input | ADDR_W | Display read address |
| dispRdata | output | DATA_W | Read data from the display's bank |
| bank0Addr | output | ADDR_W | Bank 0 address |
| bank0Wdata | output | DATA_W | Bank 0 write data |
| bank0We | output | 1 | Bank 0 write enable |
| bank0En | output | 1 | Bank 0 enable |
| bank0Rdata | input | DATA_W | Bank 0 read data |
| bank1Addr | output | ADDR_W | Bank 1 address |
| bank1Wdata | output | DATA_W | Bank 1 write data |
| bank1We | output | 1 | Bank 1 write enable |
| bank1En | output | 1 | Bank 1 enable |
| bank1Rdata | input | DATA_W | Bank 1 read data |

## Verification
The hardest case to reach is a swap that commits while a CPU write is still in progress. The bench opens a long write, requests a flip and pulses vertical blank in the display domain. It then waits until `cpuOwnBank` reports the new bank before it looks at the bank pins. At that point the write enable must still be on the old bank, and it must move only when the next access starts. The bench also holds a request for many cycles with blanking low, to show that the routing does not move early.

// File: rtl/vram_swap_pkg.sv
package vram_swap_pkg;
  // Bank choice exchanged between control and datapath
  typedef struct packed {
    logic cpuBank;   // bank driven by the CPU port (lock applied)
    logic dispBank;  // bank driven by the display port
  } bank_sel_t;
endpackage

// File: rtl/vram_swap_sync.sv
module vram_swap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/vram_swap_ctrl.sv
module vram_swap_ctrl
  import vram_swap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      cpuClk,
  input  logic      cpuRstN,
  input  logic      cpuSel,
  input  logic      flipWe,
  input  logic      flipVal,
  output logic      cpuOwnBank,
  output logic      flipPending,
  input  logic      dispClk,
  input  logic      dispRstN,
  input  logic      vblank,
  output bank_sel_t sel
);
  logic pendReg;
  logic pendDisp;
  logic activeSel;
  logic activeCpu;
  logic lockValid;
  logic lockedBank;

  // CPU domain: request register
  always_ff @(posedge cpuClk or negedge cpuRstN)
    if (!cpuRstN)    pendReg <= 1'b0;
    else if (flipWe) pendReg <= flipVal;

  vram_swap_sync #(.STAGES(SYNC_STAGES)) u_toDisp (
    .clk(dispClk), .rstN(dispRstN), .din(pendReg), .dout(pendDisp)
  );

  // Display domain: commit only inside vertical blanking
  always_ff @(posedge dispClk or negedge dispRstN)
    if (!dispRstN)   activeSel <= 1'b0;
    else if (vblank) activeSel <= pendDisp;

  vram_swap_sync #(.STAGES(SYNC_STAGES)) u_toCpu (
    .clk(cpuClk), .rstN(cpuRstN), .din(activeSel), .dout(activeCpu)
  );

  // Hold the bank for the length of one CPU access
  always_ff @(posedge cpuClk or negedge cpuRstN)
    if (!cpuRstN) begin
      lockValid  <= 1'b0;
      lockedBank <= 1'b0;
    end else if (!cpuSel) begin
      lockValid  <= 1'b0;
    end else if (!lockValid) begin
      lockValid  <= 1'b1;
      lockedBank <= activeCpu;
    end

  assign sel.cpuBank  = lockValid ? lockedBank : activeCpu;
  assign sel.dispBank = ~activeSel;
  assign cpuOwnBank   = activeCpu;
  assign flipPending  = pendReg ^ activeCpu;
endmodule

// File: rtl/vram_swap_dpath.sv
module vram_swap_dpath
  import vram_swap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int BANKS = 2
) (
  input  bank_sel_t               sel,
  input  logic                    cpuSel,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  output logic [DATA_W-1:0]       cpuRdata,
  input  logic                    dispRe,
  input  logic [ADDR_W-1:0]       dispAddr,
  output logic [DATA_W-1:0]       dispRdata,
  output logic [BANKS-1:0][ADDR_W-1:0] bankAddr,
  output logic [BANKS-1:0][DATA_W-1:0] bankWdata,
  output logic [BANKS-1:0]        bankWe,
  output logic [BANKS-1:0]        bankEn,
  input  logic [BANKS-1:0][DATA_W-1:0] bankRdata
);
  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic cpuOwns;
      assign cpuOwns = (sel.cpuBank == b[0]);
      always_comb begin
        if (cpuOwns) begin
          bankAddr[b]  = cpuAddr;
          bankWdata[b] = cpuWdata;
          bankEn[b]    = cpuSel;
          bankWe[b]    = cpuSel & cpuWe;
        end else begin
          bankAddr[b]  = dispAddr;
          bankWdata[b] = '0;
          bankEn[b]    = dispRe;
          bankWe[b]    = 1'b0;
        end
      end
    end
  endgenerate

  assign cpuRdata  = bankRdata[sel.cpuBank];
  assign dispRdata = bankRdata[sel.dispBank];
endmodule

// File: rtl/vram_swap_top.sv
module vram_swap_top
  import vram_swap_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              flipWe,
  input  logic              flipVal,
  output logic              cpuOwnBank,
  output logic              flipPending,
  input  logic              dispClk,
  input  logic              dispRstN,
  input  logic              vblank,
  input  logic              dispRe,
  input  logic [ADDR_W-1:0] dispAddr,
  output logic [DATA_W-1:0] dispRdata,
  output logic [ADDR_W-1:0] bank0Addr,
  output logic [DATA_W-1:0] bank0Wdata,
  output logic              bank0We,
  output logic              bank0En,
  input  logic [DATA_W-1:0] bank0Rdata,
  output logic [ADDR_W-1:0] bank1Addr,
  output logic [DATA_W-1:0] bank1Wdata,
  output logic              bank1We,
  output logic              bank1En,
  input  logic [DATA_W-1:0] bank1Rdata
);
  bank_sel_t selBus;
  logic      cpuBankNow;
  logic      dispBankNow;
  logic [1:0][ADDR_W-1:0] addrBus;
  logic [1:0][DATA_W-1:0] wdataBus;
  logic [1:0][DATA_W-1:0] rdataBus;
  logic [1:0]             weBus;
  logic [1:0]             enBus;

  vram_swap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN), .cpuSel(cpuSel),
    .flipWe(flipWe), .flipVal(flipVal),
    .cpuOwnBank(cpuOwnBank), .flipPending(flipPending),
    .dispClk(dispClk), .dispRstN(dispRstN), .vblank(vblank),
    .sel(selBus)
  );

  assign rdataBus[0] = bank0Rdata;
  assign rdataBus[1] = bank1Rdata;

  vram_swap_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .sel(selBus), .cpuSel(cpuSel), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .dispRe(dispRe), .dispAddr(dispAddr), .dispRdata(dispRdata),
    .bankAddr(addrBus), .bankWdata(wdataBus), .bankWe(weBus),
    .bankEn(enBus), .bankRdata(rdataBus)
  );

  assign bank0Addr  = addrBus[0];
  assign bank0Wdata = wdataBus[0];
  assign bank0We    = weBus[0];
  assign bank0En    = enBus[0];
  assign bank1Addr  = addrBus[1];
  assign bank1Wdata = wdataBus[1];
  assign bank1We    = weBus[1];
  assign bank1En    = enBus[1];

  assign cpuBankNow  = selBus.cpuBank;
  assign dispBankNow = selBus.dispBank;
endmodule

// File: rtl/vram_swap_chk.sv
module vram_swap_chk (
  input logic cpuClk,
  input logic cpuRstN,
  input logic dispClk,
  input logic dispRstN,
  input logic cpuSel,
  input logic cpuWe,
  input logic vblank,
  input logic cpuBankNow,
  input logic dispBankNow,
  input logic bank0We,
  input logic bank1We
);
  // R6
  wr_from_cpu_chk: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (bank0We || bank1We) |-> (cpuSel && cpuWe));

  // R6
  single_wr_bank_chk: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    !(bank0We && bank1We));

  // R4
  hold_outside_blank_chk: assert property (@(posedge dispClk) disable iff (!dispRstN)
    !vblank |=> $stable(dispBankNow));

  // R7
  access_bank_lock_chk: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    (cpuSel && $past(cpuSel)) |-> $stable(cpuBankNow));
endmodule

bind vram_swap_top vram_swap_chk u_chk (
  .cpuClk(cpuClk), .cpuRstN(cpuRstN), .dispClk(dispClk), .dispRstN(dispRstN),
  .cpuSel(cpuSel), .cpuWe(cpuWe), .vblank(vblank),
  .cpuBankNow(cpuBankNow), .dispBankNow(dispBankNow),
  .bank0We(bank0We), .bank1We(bank1We)
);

// File: tb/vram_swap_top_bench.sv
module vram_swap_top_bench;
  localparam int AW = 10;
  localparam int DW = 8;

  logic cpuClk = 0, dispClk = 0, cpuRstN = 0, dispRstN = 0;
  logic cpuSel = 0, cpuWe = 0, flipWe = 0, flipVal = 0;
  logic [AW-1:0] cpuAddr = '0, dispAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic vblank = 0, dispRe = 0;
  logic [DW-1:0] cpuRdata, dispRdata;
  logic cpuOwnBank, flipPending;
  logic [AW-1:0] bank0Addr, bank1Addr;
  logic [DW-1:0] bank0Wdata, bank1Wdata;
  logic bank0We, bank0En, bank1We, bank1En;
  logic [DW-1:0] bank0Rdata = 8'hA5, bank1Rdata = 8'h3C;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 cpuClk = ~cpuClk;
  always #17 dispClk = ~dispClk;

  vram_swap_top #(.ADDR_W(AW), .DATA_W(DW)) u_vram_swap_top (
    .cpuClk, .cpuRstN, .cpuSel, .cpuWe, .cpuAddr, .cpuWdata, .cpuRdata,
    .flipWe, .flipVal, .cpuOwnBank, .flipPending,
    .dispClk, .dispRstN, .vblank, .dispRe, .dispAddr, .dispRdata,
    .bank0Addr, .bank0Wdata, .bank0We, .bank0En, .bank0Rdata,
    .bank1Addr, .bank1Wdata, .bank1We, .bank1En, .bank1Rdata
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic requestFlip(input logic v);
    @(negedge cpuClk); flipWe = 1; flipVal = v;
    @(negedge cpuClk); flipWe = 0;
  endtask

  task automatic pulseBlank();
    @(negedge dispClk); vblank = 1;
    repeat (4) @(negedge dispClk);
    vblank = 0;
    repeat (6) @(negedge cpuClk);
  endtask

  task automatic testReset();
    @(negedge cpuClk);
    cpuSel = 1; cpuWe = 1; cpuAddr = 10'h123; cpuWdata = 8'h5A;
    dispRe = 1; dispAddr = 10'h055;
    #2;
    chk("R1", "cpuOwnBank", cpuOwnBank, 0);
    chk("R1", "flipPending", flipPending, 0);
    chk("R2", "bank0Addr", bank0Addr, 10'h123);
    chk("R2", "bank0We", bank0We, 1);
    chk("R2", "bank0Wdata", bank0Wdata, 8'h5A);
    chk("R2", "cpuRdata", cpuRdata, 8'hA5);
    chk("R3", "bank1Addr", bank1Addr, 10'h055);
    chk("R3", "bank1En", bank1En, 1);
    chk("R3", "bank1We", bank1We, 0);
    chk("R3", "dispRdata", dispRdata, 8'h3C);
    @(negedge cpuClk); cpuSel = 0; cpuWe = 0;
  endtask

  task automatic testHoldOutsideBlank();
    requestFlip(1);
    #2 chk("R8", "flipPending after request", flipPending, 1);
    repeat (30) @(negedge cpuClk);
    chk("R4", "flipPending while waiting", flipPending, 1);
    chk("R4", "cpuOwnBank while waiting", cpuOwnBank, 0);
    chk("R4", "dispRdata while waiting", dispRdata, 8'h3C);
    chk("R4", "bank1Addr while waiting", bank1Addr, 10'h055);
  endtask

  task automatic testCommit();
    pulseBlank();
    @(negedge cpuClk);
    cpuSel = 1; cpuWe = 1; cpuAddr = 10'h2AA;
    #2;
    chk("R5", "cpuOwnBank after blank", cpuOwnBank, 1);
    chk("R5", "flipPending after blank", flipPending, 0);
    chk("R5", "bank1We cpu write", bank1We, 1);
    chk("R5", "bank1Addr cpu", bank1Addr, 10'h2AA);
    chk("R5", "bank0Addr display", bank0Addr, 10'h055);
    chk("R6", "bank0We display", bank0We, 0);
    chk("R5", "cpuRdata", cpuRdata, 8'h3C);
    chk("R5", "dispRdata", dispRdata, 8'hA5);
  endtask

  task automatic testLockMidAccess();
    // access opened in testCommit on bank 1 is still active
    requestFlip(0);
    pulseBlank();
    #2;
    chk("R7", "cpuOwnBank committed", cpuOwnBank, 0);
    chk("R7", "bank1We held", bank1We, 1);
    chk("R7", "bank0We held off", bank0We, 0);
    @(negedge cpuClk); cpuSel = 0;
    @(negedge cpuClk); cpuSel = 1;
    #2;
    chk("R7", "bank0We next access", bank0We, 1);
    chk("R7", "bank1We next access", bank1We, 0);
    @(negedge cpuClk); cpuSel = 0; cpuWe = 0;
  endtask

  task automatic testSameValue();
    requestFlip(0);
    #2 chk("R8", "flipPending same value", flipPending, 0);
    pulseBlank();
    chk("R8", "cpuOwnBank unchanged", cpuOwnBank, 0);
  endtask

  initial begin
    repeat (3) @(negedge cpuClk);
    cpuRstN = 1; dispRstN = 1;
    repeat (2) @(negedge cpuClk);
    testReset();
    testHoldOutsideBlank();
    testCommit();
    testLockMidAccess();
    testSameValue();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge cpuClk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule